// File: doc/BRIEF.md
# Keypad Priority Encoder to BCD

This block converts the switch lines of a ten-key panel into a 4-bit binary-coded-decimal key code. Keys 1 to 9 each have their own line, and a switch closure pulls that line low. The zero key has no line of its own. When no line is pulled low, the block reports 0000, so the zero key and "nothing pressed" give the same code. When several lines are low at the same moment, the key with the highest number sets the code.

A parameter selects one of two variants. In the combinational variant the code follows the key lines within the same cycle, and no storage sits on the path. In the registered variant each raw line first passes through a two-flop synchronizer. The encoded result is then held in an output register that clears on a synchronous reset. A separate `any_key` flag shows whether any of the nine lines is asserted.

Top module: `keypad_bcd_encoder`

## Requirements
- R1: Input bit `key_n[i]` belongs to key i+1, so bit 0 is key 1 and bit 8 is key 9. A line is asserted at logic 0. With exactly one line asserted, `code` is the binary value of that key number.
- R2: With all nine lines at logic 1, `code` is 0000.
- R3: With two or more lines asserted, `code` is the number of the highest asserted key. Key 9 outranks every other key and key 1 ranks lowest. Keys 3 and 7 together give 0111.
- R4: `any_key` is 1 exactly when at least one line is at logic 0. It is therefore 1 exactly when `code` is nonzero.
- R5: `code` never exceeds 9 (1001). Whenever key 9 is asserted, `code` is 1001.
- R6: With REGISTERED=0, `code` and `any_key` depend only on the present `key_n`. No clock edge is needed for the outputs to follow a change.
- R7: With REGISTERED=1, a change on `key_n` that is set up before rising edge k appears on `code` and `any_key` just after rising edge k+2. The outputs hold their old values after edges k and k+1.
- R8: With REGISTERED=1, a clock edge with `rst` high sets `code` to 0000 and `any_key` to 0, and returns both synchronizer stages to the idle (all ones) state. After `rst` falls, a held key appears only after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the registered variant |
| rst | input | 1 | Synchronous active-high reset for the registered variant |
| key_n | input | 9 | Key lines 1 to 9, asserted when low; bit 0 is key 1 |
| code | output | 4 | Active-high BCD key code |
| any_key | output | 1 | High when any key line is asserted |

## Verification
The assertions check on every cycle that:
- the code stays in the range 0 to 9;
- `any_key` agrees with a nonzero code;
- an asserted key 9 yields 1001;
- in the registered variant, reset clears the outputs;
- in the registered variant, a line set that stays idle for three cycles produces 0000.

Only the bench's sweep shows the full priority mapping over all 512 line patterns, including ties such as keys 3 and 7. The same goes for the exact edge at which a registered change appears. So does the delayed appearance of a held key after reset is released.

// File: rtl/keypad_bcd_encoder.sv
module keypad_bcd_encoder #(
  parameter int KEYS = 9,
  parameter bit REGISTERED = 1'b1,
  localparam int CODE_W = $clog2(KEYS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEYS-1:0]   key_n,
  output logic [CODE_W-1:0] code,
  output logic              any_key
);

  logic [KEYS-1:0]   lines;
  logic [CODE_W-1:0] enc;
  logic              hit;

  always_comb begin
    enc = '0;
    for (int i = 0; i < KEYS; i++)
      if (!lines[i]) enc = CODE_W'(i + 1);
  end

  assign hit = ~&lines;

  generate
    if (REGISTERED) begin : g_reg
      logic [KEYS-1:0]   meta_q, sync_q;
      logic [CODE_W-1:0] code_q;
      logic              any_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= '1;
          sync_q <= '1;
          code_q <= '0;
          any_q  <= 1'b0;
        end else begin
          meta_q <= key_n;
          sync_q <= meta_q;
          code_q <= enc;
          any_q  <= hit;
        end
      end

      assign lines   = sync_q;
      assign code    = code_q;
      assign any_key = any_q;

      // R8
      rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (code == '0 && !any_key));

      // R2
      idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) &&
         &$past(key_n, 1) && &$past(key_n, 2) && &$past(key_n, 3))
        |-> (code == '0 && !any_key));
    end else begin : g_comb
      assign lines   = key_n;
      assign code    = enc;
      assign any_key = hit;

      // R5
      top_key_chk: assert property (@(posedge clk) disable iff (rst)
        !key_n[KEYS-1] |-> code == CODE_W'(KEYS));

      // R2
      idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        &key_n |-> (code == '0 && !any_key));
    end
  endgenerate

  // R5
  code_range_chk: assert property (@(posedge clk) disable iff (rst)
    code <= CODE_W'(KEYS));

  // R4
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    any_key == (code != '0));

endmodule

// File: tb/sim_keypad_bcd_encoder.sv
`timescale 1ns/1ps
module sim_keypad_bcd_encoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] key_n = 9'h1FF;
  logic [3:0] code_r, code_c;
  logic       any_r, any_c;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  keypad_bcd_encoder #(.KEYS(9), .REGISTERED(1'b1)) u0 (
    .clk(clk), .rst(rst), .key_n(key_n), .code(code_r), .any_key(any_r));
  keypad_bcd_encoder #(.KEYS(9), .REGISTERED(1'b0)) u1 (
    .clk(clk), .rst(rst), .key_n(key_n), .code(code_c), .any_key(any_c));

  function automatic int expect_code(logic [8:0] p);
    int e = 0;
    for (int i = 1; i <= 9; i++) if (p[i-1] == 1'b0) e = i;
    return e;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int prev;
    int e;
    @(negedge clk);
    key_n = 9'b111_101_111;
    step; step;
    check("R8 reset code", code_r, 0);
    check("R8 reset any_key", any_r, 0);
    rst = 1'b0;
    step; step;
    check("R8 held key hidden after 2 edges", code_r, 0);
    step;
    check("R8 held key shown after 3rd edge", code_r, 5);
    prev = 5;

    for (int p = 0; p < 512; p++) begin
      key_n = p[8:0];
      e = expect_code(p[8:0]);
      #1;
      check("R1/R2/R3 comb code", code_c, e);
      check("R4 comb any_key", any_c, (p != 511) ? 1 : 0);
      check("R6 comb same cycle", code_c, e);
      if (!key_n[8]) check("R5 key9 comb", code_c, 9);
      @(negedge clk);
      step;
      check("R7 reg hold after 2 edges", code_r, prev);
      step;
      check("R1/R2/R3 reg code", code_r, e);
      check("R4 reg any_key", any_r, (e != 0) ? 1 : 0);
      prev = e;
    end

    key_n = 9'b110_111_011;
    #1;
    check("R3 keys 3 and 7", code_c, 7);
    key_n = 9'b111_111_110;
    #1;
    check("R1 key 1 alone", code_c, 1);
    key_n = 9'h1FF;
    #1;
    check("R2 idle", code_c, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule